// File: doc/BRIEF.md
# Mode-Switchable Receive Byte Queue

This block holds received bytes for a legacy-style serial port until the host reads them out of the data register. Its usable capacity is picked at run time: a single byte in character mode, or sixteen bytes in buffered mode. Bytes arrive on a push interface with valid and ready signals. The receiver and an internal loopback path both feed that interface. Bytes leave on a pop strobe, which comes from host reads of the data register.

Every change of the mode input throws the contents away and returns both pointers and the count to zero. A receiver-flush command given while buffered mode is selected does the same. The block reports its occupancy, a registered not-empty flag and a one-cycle reject pulse. A push that meets a full queue produces that pulse, and the register layer uses it to set its overrun bit.

Top module: `swrx_fifo`

## Requirements
- R1: After reset the count is 0, not_empty is 0, push_reject is 0, and the capacity is 1 (character mode), so push_ready is 1.
- R2: In character mode (mode input 0) one stored byte fills the queue. push_ready then drops and a further push is refused.
- R3: In buffered mode (mode input 1) the queue accepts 16 bytes before push_ready drops.
- R4: A cycle in which the mode input differs from the current mode flushes the queue, in either direction. After that clock edge the count is 0, the new capacity applies, and any push or pop given in that cycle is ignored.
- R5: rcv_flush in a cycle with the mode input at 1 flushes the queue and leaves the capacity at 16. rcv_flush with the mode input at 0 has no effect.
- R6: A push while the count equals the capacity is refused. The stored bytes stay unchanged, and push_reject is 1 for exactly the cycle after that edge.
- R7: Bytes leave in the order they were accepted. Both pointers wrap at the current capacity, so ordering holds across any number of wraps.
- R8: The count rises by one on an accepted push and falls by one on a pop of a non-empty queue.
- R9: pop_data shows the oldest byte while not empty, and 8'hFF while empty. A pop of an empty queue changes nothing.
- R10: A push together with a pop on a non-empty, non-full queue leaves the count unchanged and keeps the order.
- R11: not_empty is a register whose value always equals (count != 0).
- R12: push_ready is 1 exactly when the count is below the current capacity, and the count never exceeds that capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| buf_mode | input | 1 | Mode select: 1 selects buffered (16 entries), 0 selects character (1 entry) |
| rcv_flush | input | 1 | Receiver flush command; acts only while buf_mode is 1 |
| push_valid | input | 1 | A byte is offered |
| push_data | input | 8 | Offered byte |
| push_ready | output | 1 | Space remains at the current capacity |
| pop | input | 1 | Host read of the data register |
| pop_data | output | 8 | Oldest byte, or 8'hFF when empty |
| count | output | 5 | Number of stored bytes |
| not_empty | output | 1 | Registered flag, equal to count != 0 |
| push_reject | output | 1 | One-cycle pulse after a refused push |

## Verification
Directed sequences come first. They fill the queue in each mode to show that the capacity is 1 or 16. They overfill it to tell refusal apart from overwriting. They cycle push and pop past 16 entries to show that the wrap point follows the capacity. They issue a flush in each mode to tell the two rcv_flush cases apart. A long stream of seeded random pushes, pops, mode flips and flushes follows, checked every cycle against a queue model. That stream covers simultaneous push and pop, pops of an empty queue, and mode changes that collide with traffic.

// File: rtl/swrx_pkg.sv
package swrx_pkg;

  // capacity for a given mode: buffered mode uses the full depth
  function automatic int unsigned cap_of(input logic buffered, input int unsigned depth);
    return buffered ? depth : 1;
  endfunction

  // pointer advance that wraps at the active capacity
  function automatic int unsigned ptr_step(input int unsigned p, input int unsigned cap);
    return (p + 1 >= cap) ? 0 : p + 1;
  endfunction

endpackage

// File: rtl/swrx_mode_ctl.sv
module swrx_mode_ctl #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode,
  input  logic          rcv_flush,
  output logic          flush,
  output logic [CW-1:0] cap
);
  import swrx_pkg::*;

  logic mode_q;

  // any edge of the mode input, or a receiver flush in buffered mode
  assign flush = (buf_mode ^ mode_q) | (rcv_flush & buf_mode);
  assign cap   = CW'(cap_of(mode_q, DEPTH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= buf_mode;
  end
endmodule

// File: rtl/swrx_track.sv
module swrx_track #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] cap,
  input  logic          push_valid,
  input  logic          pop,
  output logic          push_ready,
  output logic          push_acc,
  output logic          pop_acc,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [CW-1:0] count,
  output logic          not_empty,
  output logic          push_reject
);
  import swrx_pkg::*;

  logic [CW-1:0] count_n;

  assign push_ready = (count < cap);
  assign push_acc   = push_valid & push_ready & ~flush;
  assign pop_acc    = pop & (count != '0) & ~flush;

  always_comb begin
    count_n = count;
    if (flush)                     count_n = '0;
    else if (push_acc && !pop_acc) count_n = count + 1'b1;
    else if (pop_acc && !push_acc) count_n = count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      count       <= '0;
      not_empty   <= 1'b0;
      push_reject <= 1'b0;
    end else begin
      count       <= count_n;
      not_empty   <= (count_n != '0);
      push_reject <= push_valid & ~push_ready & ~flush;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_acc) wr_ptr <= PW'(ptr_step(int'(wr_ptr), int'(cap)));
        if (pop_acc)  rd_ptr <= PW'(ptr_step(int'(rd_ptr), int'(cap)));
      end
    end
  end
endmodule

// File: rtl/swrx_store.sv
module swrx_store #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [PW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/swrx_fifo.sv
module swrx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 8,
  localparam int unsigned PW = $clog2(DEPTH),
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_mode,
  input  logic          rcv_flush,
  input  logic          push_valid,
  input  logic [W-1:0]  push_data,
  output logic          push_ready,
  input  logic          pop,
  output logic [W-1:0]  pop_data,
  output logic [CW-1:0] count,
  output logic          not_empty,
  output logic          push_reject
);
  logic          flush;
  logic [CW-1:0] cap;
  logic          push_acc;
  logic          pop_acc;
  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [W-1:0]  head;

  swrx_mode_ctl #(.DEPTH(DEPTH)) u_mode (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .rcv_flush(rcv_flush),
    .flush(flush), .cap(cap)
  );

  swrx_track #(.DEPTH(DEPTH)) u_track (
    .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap),
    .push_valid(push_valid), .pop(pop), .push_ready(push_ready),
    .push_acc(push_acc), .pop_acc(pop_acc), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
    .count(count), .not_empty(not_empty), .push_reject(push_reject)
  );

  swrx_store #(.DEPTH(DEPTH), .W(W)) u_store (
    .clk(clk), .we(push_acc), .waddr(wr_ptr), .wdata(push_data),
    .raddr(rd_ptr), .rdata(head)
  );

  assign pop_data = not_empty ? head : '1;
endmodule

// File: rtl/swrx_fifo_chk.sv
module swrx_fifo_chk #(
  parameter int unsigned CW = 5,
  parameter int unsigned W  = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          flush,
  input logic [CW-1:0] cap,
  input logic [CW-1:0] count,
  input logic          not_empty,
  input logic          push_valid,
  input logic          push_ready,
  input logic          push_acc,
  input logic          push_reject,
  input logic          pop,
  input logic [W-1:0]  pop_data
);
  // R12
  count_le_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= cap);
  // R4
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0));
  // R11
  ne_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    not_empty == (count != '0));
  // R6
  full_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !flush) |=> push_reject);
  // R6
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && !push_ready && !pop && !flush) |=> $stable(count));
  // R9
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !not_empty && !push_valid && !flush) |=> (count == '0));
  // R9
  empty_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !not_empty |-> (pop_data == '1));
  // R10
  pushpop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_acc && pop && not_empty && !flush) |=> $stable(count));
endmodule

bind swrx_fifo swrx_fifo_chk #(.CW(CW), .W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .cap(cap), .count(count),
  .not_empty(not_empty), .push_valid(push_valid), .push_ready(push_ready),
  .push_acc(push_acc), .push_reject(push_reject), .pop(pop), .pop_data(pop_data)
);

// File: tb/swrx_fifo_tb.sv
module swrx_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       buf_mode = 1'b0, rcv_flush = 1'b0, push_valid = 1'b0, pop = 1'b0;
  logic [7:0] push_data = '0;
  logic       push_ready, not_empty, push_reject;
  logic [7:0] pop_data;
  logic [4:0] count;

  int checks = 0, errors = 0;
  logic [7:0] mq[$];
  logic mmode = 1'b0;
  logic mrej  = 1'b0;

  always #5 clk = ~clk;

  swrx_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .buf_mode(buf_mode), .rcv_flush(rcv_flush),
    .push_valid(push_valid), .push_data(push_data), .push_ready(push_ready),
    .pop(pop), .pop_data(pop_data), .count(count), .not_empty(not_empty),
    .push_reject(push_reject)
  );

  function automatic int bcap(input logic m);
    return m ? 16 : 1;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock cycle: drive, check comb outputs, update model, check registers
  task automatic cyc(input logic bm, input logic rf, input logic pv,
                     input logic [7:0] pd, input logic pp);
    int sz;
    logic fl;
    @(negedge clk);
    buf_mode = bm; rcv_flush = rf; push_valid = pv; push_data = pd; pop = pp;
    #1;
    sz = mq.size();
    chk("R12 push_ready", int'(push_ready), int'(sz < bcap(mmode)));
    chk("R9 pop_data", int'(pop_data), sz > 0 ? int'(mq[0]) : 255);
    fl = (bm != mmode) || (rf && bm);
    @(posedge clk);
    if (fl) begin
      mq.delete();
      mmode = bm;
      mrej = 1'b0;
    end else begin
      mrej = pv && (sz >= bcap(mmode));
      if (pp && sz > 0) void'(mq.pop_front());
      if (pv && sz < bcap(mmode)) mq.push_back(pd);
    end
    #1;
    chk("R8 count", int'(count), mq.size());
    chk("R11 not_empty", int'(not_empty), int'(mq.size() != 0));
    chk("R6 push_reject", int'(push_reject), int'(mrej));
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5eed));
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", int'(count), 0);
    chk("R1 not_empty", int'(not_empty), 0);
    chk("R1 push_ready", int'(push_ready), 1);
    chk("R1 push_reject", int'(push_reject), 0);
    chk("R9 empty pop_data", int'(pop_data), 255);
    @(negedge clk); rst_n = 1'b1;

    // R2 character mode holds one byte; second push refused, first kept
    cyc(0, 0, 1, 8'h41, 0);
    cyc(0, 0, 1, 8'h42, 0);
    chk("R2 full ready low", int'(push_ready), 0);
    chk("R6 data kept", int'(pop_data), 8'h41);
    // R5 rcv_flush in character mode ignored
    cyc(0, 1, 0, 0, 0);
    chk("R5 char flush ignored", int'(count), 1);
    // R4 mode change flushes, concurrent push ignored
    cyc(1, 0, 1, 8'h55, 0);
    chk("R4 flush to buffered", int'(count), 0);
    // R3 sixteen entries, then R6 reject
    for (int i = 0; i < 17; i++) cyc(1, 0, 1, 8'(8'h10 + i), 0);
    chk("R3 capacity 16", int'(count), 16);
    chk("R6 reject pulse", int'(push_reject), 1);
    cyc(1, 0, 0, 0, 0);
    chk("R6 pulse single", int'(push_reject), 0);
    // R5 receiver flush in buffered mode keeps capacity 16
    cyc(1, 1, 0, 0, 0);
    chk("R5 buffered flush", int'(count), 0);
    for (int i = 0; i < 16; i++) cyc(1, 0, 1, 8'(8'hA0 + i), 0);
    chk("R5 capacity kept", int'(count), 16);
    // R9 drain and pop empty
    for (int i = 0; i < 18; i++) cyc(1, 0, 0, 0, 1);
    chk("R9 empty after pops", int'(count), 0);
    // R7 R10 wrap with push+pop stream
    cyc(1, 0, 1, 8'h01, 0);
    for (int i = 0; i < 40; i++) cyc(1, 0, 1, 8'(i + 2), 1);
    chk("R10 count steady", int'(count), 1);
    // R4 back to character mode
    cyc(0, 0, 0, 0, 1);
    chk("R4 flush to char", int'(count), 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 8'(8'hC0 + i), 1);

    // random mix, R7 ordering checked via pop_data each cycle
    for (int i = 0; i < 4000; i++) begin
      logic bm;
      bm = u_dut.buf_mode;
      if ($urandom_range(0, 59) == 0) bm = ~bm;
      cyc(bm, $urandom_range(0, 49) == 0, $urandom_range(0, 99) < 60,
          8'($urandom), $urandom_range(0, 99) < 45);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule